// File: doc/BRIEF.md
# Bus Mastership Direction Controller

This block joins two segments of an asynchronous, open-collector style backplane bus: the left segment, where the processor lives, and the right segment, which extends the bus. It watches the bus-busy line on both segments. Whichever segment asserts bus-busy first becomes the source side. The block then repeats bus-busy onto the other segment and raises exactly one of two address-direction enables. That direction holds until the originating master releases bus-busy.

While a direction is active, the 18 address lines and the two cycle-type control lines pass from the source side to the far side. Lines in the other direction stay released. The DC-power-low line can be driven from either segment, so it is repeated by a second owner tracker that uses the same first-side-wins rule. An inhibit input blocks every address-direction enable.

All bus lines are active low: a logic 0 means asserted and a logic 1 means released. Each side has a separate input vector and a separate output vector. Ownership is sampled on the rising clock edge, so an owner change shows at the outputs one cycle after the input that causes it. The address and control gating is combinational from the registered enables.

Top module: `bus_dir_ctl`

## Requirements
- R1: After reset both address enables are 0, and every bus output (busy, power-low, address, cycle-type, on both sides) is 1 (released).
- R2: With inhibit low and no owner, a left busy input of 0 while the right busy input is 1 gives, one clock later, `a_l2r`=1, `r_busy_o_n`=0 and `l_busy_o_n`=1.
- R3: With inhibit low and no owner, a right busy input of 0 while the left busy input is 1 gives, one clock later, `a_r2l`=1, `l_busy_o_n`=0 and `r_busy_o_n`=1.
- R4: When the owning side's busy input returns to 1, the enable and the repeated busy on the far side both return to idle one clock later.
- R5: While one direction is active, a busy input of 0 on the far segment does not change the enable, does not raise the other enable, and does not drive busy back onto the owning side.
- R6: If both busy inputs go to 0 in the same clock with no owner, the left side wins (`a_l2r`=1, `a_r2l`=0).
- R7: While inhibit is 1, no address enable and no repeated busy is produced. Raising inhibit during an active direction clears it one clock later.
- R8: The address lines (18 bits) and the cycle-type lines (2 bits) are copied from the source side to the far side only while that direction's enable is 1. All other address and cycle-type outputs are all ones.
- R9: The power-low line uses its own owner tracker with the same first-side-wins, left-priority and hold-until-release rules. It is not affected by inhibit.
- R10: `a_l2r` and `a_r2l` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inhibit | input | 1 | 1 blocks both address enables |
| l_busy_n | input | 1 | Busy line seen on the left segment |
| r_busy_n | input | 1 | Busy line seen on the right segment |
| l_busy_o_n | output | 1 | Busy driven onto the left segment |
| r_busy_o_n | output | 1 | Busy driven onto the right segment |
| l_pwrlo_n | input | 1 | Power-low seen on the left segment |
| r_pwrlo_n | input | 1 | Power-low seen on the right segment |
| l_pwrlo_o_n | output | 1 | Power-low driven onto the left segment |
| r_pwrlo_o_n | output | 1 | Power-low driven onto the right segment |
| l_addr_n | input | 18 | Address lines seen on the left segment |
| r_addr_n | input | 18 | Address lines seen on the right segment |
| l_addr_o_n | output | 18 | Address lines driven onto the left segment |
| r_addr_o_n | output | 18 | Address lines driven onto the right segment |
| l_cyc_n | input | 2 | Cycle-type lines seen on the left segment |
| r_cyc_n | input | 2 | Cycle-type lines seen on the right segment |
| l_cyc_o_n | output | 2 | Cycle-type lines driven onto the left segment |
| r_cyc_o_n | output | 2 | Cycle-type lines driven onto the right segment |
| a_l2r | output | 1 | Address direction enable, left to right |
| a_r2l | output | 1 | Address direction enable, right to left |

## Verification
A wrong owner bit shows at the ports within one clock. It appears as a repeated busy on the wrong segment, an enable that outlives its master's release, or an address word leaking onto the side that sources it. The checks therefore compare both busy outputs, both enables and both address outputs in the cycle after every input change. Contention cases carry the most risk: a far-side busy arriving during ownership, both sides asserting together, and inhibit arriving mid-transfer. The power-low tracker is checked separately to show it ignores inhibit.

// File: rtl/bus_dir_ctl.sv
module bus_dir_ctl #(
  parameter int AW = 18,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inhibit,
  input  logic          l_busy_n,
  input  logic          r_busy_n,
  output logic          l_busy_o_n,
  output logic          r_busy_o_n,
  input  logic          l_pwrlo_n,
  input  logic          r_pwrlo_n,
  output logic          l_pwrlo_o_n,
  output logic          r_pwrlo_o_n,
  input  logic [AW-1:0] l_addr_n,
  input  logic [AW-1:0] r_addr_n,
  output logic [AW-1:0] l_addr_o_n,
  output logic [AW-1:0] r_addr_o_n,
  input  logic [CW-1:0] l_cyc_n,
  input  logic [CW-1:0] r_cyc_n,
  output logic [CW-1:0] l_cyc_o_n,
  output logic [CW-1:0] r_cyc_o_n,
  output logic          a_l2r,
  output logic          a_r2l
);

  localparam logic [AW-1:0] ADDR_IDLE = '1;
  localparam logic [CW-1:0] CYC_IDLE  = '1;

  logic own_l, own_r;
  logic pwr_l, pwr_r;

  // bus-busy ownership: first side wins, left on a tie, held until release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_l <= 1'b0;
      own_r <= 1'b0;
    end else if (inhibit) begin
      own_l <= 1'b0;
      own_r <= 1'b0;
    end else if (own_l) begin
      own_l <= !l_busy_n;
    end else if (own_r) begin
      own_r <= !r_busy_n;
    end else begin
      own_l <= !l_busy_n;
      own_r <= l_busy_n && !r_busy_n;
    end
  end

  // power-low ownership: same rule, not gated by inhibit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_l <= 1'b0;
      pwr_r <= 1'b0;
    end else if (pwr_l) begin
      pwr_l <= !l_pwrlo_n;
    end else if (pwr_r) begin
      pwr_r <= !r_pwrlo_n;
    end else begin
      pwr_l <= !l_pwrlo_n;
      pwr_r <= l_pwrlo_n && !r_pwrlo_n;
    end
  end

  assign a_l2r       = own_l;
  assign a_r2l       = own_r;
  assign r_busy_o_n  = !own_l;
  assign l_busy_o_n  = !own_r;
  assign r_pwrlo_o_n = !pwr_l;
  assign l_pwrlo_o_n = !pwr_r;

  assign r_addr_o_n = own_l ? l_addr_n : ADDR_IDLE;
  assign l_addr_o_n = own_r ? r_addr_n : ADDR_IDLE;
  assign r_cyc_o_n  = own_l ? l_cyc_n  : CYC_IDLE;
  assign l_cyc_o_n  = own_r ? r_cyc_n  : CYC_IDLE;

endmodule

// File: rtl/bus_dir_ctl_chk.sv
module bus_dir_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic inhibit,
  input logic l_busy_n,
  input logic r_busy_n,
  input logic l_busy_o_n,
  input logic r_busy_o_n,
  input logic a_l2r,
  input logic a_r2l
);

  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_l2r && a_r2l));

  a_r2_left_grab: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_l2r && !a_r2l && !inhibit && !l_busy_n) |=> (a_l2r && !r_busy_o_n));

  a_r3_right_grab: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_l2r && !a_r2l && !inhibit && l_busy_n && !r_busy_n) |=> (a_r2l && !l_busy_o_n));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (a_l2r && l_busy_n) |=> !a_l2r);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (a_l2r && !l_busy_n && !inhibit) |=> (a_l2r && !a_r2l && l_busy_o_n));

  a_r7_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (!a_l2r && !a_r2l && l_busy_o_n && r_busy_o_n));

endmodule

bind bus_dir_ctl bus_dir_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_busy_o_n(l_busy_o_n), .r_busy_o_n(r_busy_o_n),
  .a_l2r(a_l2r), .a_r2l(a_r2l)
);

// File: tb/bus_dir_ctl_tb_top.sv
`timescale 1ns/1ps
module bus_dir_ctl_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic inhibit = 0;
  logic l_busy_n = 1, r_busy_n = 1;
  logic l_busy_o_n, r_busy_o_n;
  logic l_pwrlo_n = 1, r_pwrlo_n = 1;
  logic l_pwrlo_o_n, r_pwrlo_o_n;
  logic [17:0] l_addr_n = '1, r_addr_n = '1, l_addr_o_n, r_addr_o_n;
  logic [1:0] l_cyc_n = '1, r_cyc_n = '1, l_cyc_o_n, r_cyc_o_n;
  logic a_l2r, a_r2l;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  bus_dir_ctl dut_i (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_all();
    l_busy_n = 1; r_busy_n = 1; inhibit = 0;
    l_pwrlo_n = 1; r_pwrlo_n = 1;
    tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 a_l2r", a_l2r, 0);
    chk("R1 a_r2l", a_r2l, 0);
    chk("R1 busy outs", {l_busy_o_n, r_busy_o_n, l_pwrlo_o_n, r_pwrlo_o_n}, 4'hF);
    chk("R1 addr outs", {l_addr_o_n, r_addr_o_n}, 36'hF_FFFF_FFFF);
    chk("R1 cyc outs", {l_cyc_o_n, r_cyc_o_n}, 4'hF);
  endtask

  task automatic t_left_master();
    l_addr_n = 18'h2A5C3; l_cyc_n = 2'b01; r_addr_n = 18'h00F0F;
    l_busy_n = 0; tick();
    chk("R2 a_l2r", a_l2r, 1);
    chk("R2 busy outs l/r", {l_busy_o_n, r_busy_o_n}, 2'b10);
    chk("R8 r addr", r_addr_o_n, 18'h2A5C3);
    chk("R8 r cyc", r_cyc_o_n, 2'b01);
    chk("R8 l addr idle", l_addr_o_n, 18'h3FFFF);
    l_addr_n = 18'h1_0001; #1;
    chk("R8 r addr follows", r_addr_o_n, 18'h1_0001);
    r_busy_n = 0; tick(); tick();
    chk("R5 a_l2r held", a_l2r, 1);
    chk("R5 a_r2l stays 0", a_r2l, 0);
    chk("R5 no busy onto left", l_busy_o_n, 1);
    l_busy_n = 1; r_busy_n = 1; tick();
    chk("R4 enable drop", a_l2r, 0);
    chk("R4 far busy removed", r_busy_o_n, 1);
    chk("R8 r addr idle", r_addr_o_n, 18'h3FFFF);
    idle_all();
  endtask

  task automatic t_right_master();
    r_addr_n = 18'h155AA; r_cyc_n = 2'b10; l_addr_n = 18'h00001;
    r_busy_n = 0; tick();
    chk("R3 a_r2l", a_r2l, 1);
    chk("R3 busy outs l/r", {l_busy_o_n, r_busy_o_n}, 2'b01);
    chk("R8 l addr", l_addr_o_n, 18'h155AA);
    chk("R8 l cyc", l_cyc_o_n, 2'b10);
    chk("R8 r addr idle", r_addr_o_n, 18'h3FFFF);
    l_busy_n = 0; tick();
    chk("R5 right held", {a_l2r, a_r2l}, 2'b01);
    chk("R5 no busy onto right", r_busy_o_n, 1);
    r_busy_n = 1; tick();
    chk("R4 right release", a_r2l, 0);
    // left still asserting: takes ownership next cycle
    tick();
    chk("R2 left after right release", a_l2r, 1);
    idle_all();
  endtask

  task automatic t_tie();
    l_busy_n = 0; r_busy_n = 0; tick();
    chk("R6 left wins", {a_l2r, a_r2l}, 2'b10);
    idle_all();
  endtask

  task automatic t_inhibit();
    inhibit = 1; l_busy_n = 0; tick(); tick();
    chk("R7 blocked enable", {a_l2r, a_r2l}, 2'b00);
    chk("R7 blocked busy", {l_busy_o_n, r_busy_o_n}, 2'b11);
    inhibit = 0; tick();
    chk("R7 enable after inhibit low", a_l2r, 1);
    inhibit = 1; tick();
    chk("R7 mid-transfer clear", a_l2r, 0);
    chk("R7 busy removed", r_busy_o_n, 1);
    idle_all();
  endtask

  task automatic t_pwrlo();
    inhibit = 1;
    r_pwrlo_n = 0; tick();
    chk("R9 right pwrlo repeated", {l_pwrlo_o_n, r_pwrlo_o_n}, 2'b01);
    l_pwrlo_n = 0; tick();
    chk("R9 held right owner", {l_pwrlo_o_n, r_pwrlo_o_n}, 2'b01);
    r_pwrlo_n = 1; tick();
    chk("R9 release", {l_pwrlo_o_n, r_pwrlo_o_n}, 2'b11);
    tick();
    chk("R9 left takes", {l_pwrlo_o_n, r_pwrlo_o_n}, 2'b10);
    l_pwrlo_n = 1; tick(); tick();
    l_pwrlo_n = 0; r_pwrlo_n = 0; tick();
    chk("R9 tie left wins", {l_pwrlo_o_n, r_pwrlo_o_n}, 2'b10);
    idle_all();
  endtask

  task automatic t_excl();
    for (int i = 0; i < 40; i++) begin
      l_busy_n = i[0]; r_busy_n = i[1] ^ i[3]; inhibit = (i % 7) == 6;
      tick();
      chk("R10 exclusive", {31'd0, a_l2r & a_r2l}, 0);
    end
    idle_all();
  endtask

  initial begin
    #200000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    tick(); rst_n = 1; tick();
    t_reset();
    t_left_master();
    t_right_master();
    t_tie();
    t_inhibit();
    t_pwrlo();
    t_excl();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule